// File: doc/BRIEF.md
# Banked Register File with Dual Stack Pointer

This block is the architectural register file of a 16-bit core. It exposes sixteen word registers through two read ports and one write port. The low four registers exist once per bank, and a bank-select input picks which copy is visible. Registers 4 to 6 and 8 to 15 are shared by every bank. Register 7 has no storage of its own. It is a window onto one of two stack pointers, one for user mode and one for system mode, and a mode input chooses between them.

The bank select and the mode bit are taken from the processor status word. The block registers both, so a change takes effect on the cycle after it is presented. The write port writes a whole word or one byte of registers 0 to 7. A byte write to the word-only registers is refused and flagged.

Two stack strobes move the active stack pointer. On a push it steps down by two before the store. On a pop the load happens first and the pointer then steps up by two. The address the stack transfer should use is presented in the same cycle as the strobe, so a memory stage can perform the transfer.

Top module: `banked_regfile`

## Requirements
- R1: Registers 0 to 3 exist in four independent copies, and reads and writes use the copy named by the registered bank select (bank_sel 0 to 3). A write to one copy leaves the other copies unchanged.
- R2: Registers 4, 5, 6 and 8 to 15 are single copies, and every bank sees the same value.
- R3: With wr_byte=1 and wr_idx 0 to 7, only one byte of the register changes: bits 15:8 when wr_hi=1 and bits 7:0 when wr_hi=0. The new byte is taken from wr_data[7:0], and the other byte keeps its value.
- R4: A write with wr_byte=1 and wr_idx 8 to 15 raises wr_err combinationally in that cycle and changes no register.
- R5: Register 7 reads and writes the user stack pointer when the registered mode bit is 0 and the system stack pointer when it is 1. sp_out always shows the active stack pointer.
- R6: While push is high (and pop is low), stk_addr equals the active stack pointer minus 2. After the clock edge the active stack pointer holds that value.
- R7: Reset sets both stack pointers to 0x0100, every other register to 0, and the bank and mode to 0. The first push therefore addresses 0x00FE.
- R8: While pop is high (and push is low), stk_addr equals the active stack pointer. After the clock edge the active stack pointer is 2 higher.
- R9: A read of a register being written in the same cycle returns the value it will hold after the edge, with byte merging and stack adjustment included.
- R10: A new bank_sel or sys_mode value affects reads, writes and stack operations only from the next cycle onward.
- R11: Push and pop together leave the stack pointer unchanged. A port write to register 7 in the same cycle as a stack strobe takes priority over the stack adjustment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bank_sel | input | 2 | Bank for registers 0 to 3, registered |
| sys_mode | input | 1 | 1 selects the system stack pointer, registered |
| wr_en | input | 1 | Write strobe |
| wr_idx | input | 4 | Register to write |
| wr_byte | input | 1 | 1 = byte write, 0 = word write |
| wr_hi | input | 1 | For a byte write, 1 = upper byte |
| wr_data | input | 16 | Write data (bits 7:0 for a byte write) |
| wr_err | output | 1 | Refused byte write to registers 8 to 15 |
| rd_a_idx | input | 4 | Read port A register |
| rd_a_data | output | 16 | Read port A data |
| rd_b_idx | input | 4 | Read port B register |
| rd_b_data | output | 16 | Read port B data |
| push | input | 1 | Stack pre-decrement strobe |
| pop | input | 1 | Stack post-increment strobe |
| stk_addr | output | 16 | Address for this cycle's stack transfer |
| sp_out | output | 16 | Active stack pointer |

## Verification
The bench builds the block with its default parameters: sixteen 16-bit registers, four banks of four, eight byte-capable registers, a stack step of 2 and a reset pointer of 0x0100. With these values, every bank can be written and compared against the others. Both stack pointers can be driven across the mode switch. Byte writes can reach both the byte-capable registers and the word-only ones. The one-cycle delay of bank and mode changes can be seen on a read made in the same cycle as the change.

// File: rtl/rf_pkg.sv
package rf_pkg;
   typedef enum logic [1:0] {
      STK_HOLD = 2'd0,
      STK_PUSH = 2'd1,
      STK_POP  = 2'd2
   } stk_op_e;

   // push and pop together cancel out
   function automatic stk_op_e decode_stk(input logic push, input logic pop);
      if (push && !pop)      return STK_PUSH;
      else if (pop && !push) return STK_POP;
      else                   return STK_HOLD;
   endfunction
endpackage

// File: rtl/rf_bank_store.sv
module rf_bank_store #(
   parameter int DATA_W      = 16,
   parameter int NUM_BANKS   = 4,
   parameter int BANKED_REGS = 4,
   localparam int BANK_W     = $clog2(NUM_BANKS),
   localparam int BIDX_W     = $clog2(BANKED_REGS)
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic [BANK_W-1:0]                   bank_i,
   input  logic                                we_i,
   input  logic [BIDX_W-1:0]                   widx_i,
   input  logic [DATA_W-1:0]                   wdata_i,
   output logic [BANKED_REGS-1:0][DATA_W-1:0]  rd_o
);
   logic [NUM_BANKS-1:0][BANKED_REGS-1:0][DATA_W-1:0] mem_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    mem_q <= '0;
      else if (we_i) mem_q[bank_i][widx_i] <= wdata_i;
   end

   assign rd_o = mem_q[bank_i];
endmodule

// File: rtl/rf_shared_store.sv
module rf_shared_store #(
   parameter int DATA_W      = 16,
   parameter int NUM_REGS    = 16,
   parameter int BANKED_REGS = 4,
   parameter int SP_IDX      = 7,
   localparam int IDX_W      = $clog2(NUM_REGS)
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             we_i,
   input  logic [IDX_W-1:0]                 widx_i,
   input  logic [DATA_W-1:0]                wdata_i,
   output logic [NUM_REGS-1:0][DATA_W-1:0]  rd_o
);
   for (genvar i = 0; i < NUM_REGS; i++) begin : g_slot
      if (i < BANKED_REGS || i == SP_IDX) begin : g_none
         assign rd_o[i] = '0;
      end else begin : g_reg
         logic [DATA_W-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                              q <= '0;
            else if (we_i && widx_i == IDX_W'(i))    q <= wdata_i;
         end
         assign rd_o[i] = q;
      end
   end
endmodule

// File: rtl/rf_stack_ptr.sv
module rf_stack_ptr
   import rf_pkg::*;
#(
   parameter int          DATA_W     = 16,
   parameter logic [15:0] SP_RESET   = 16'h0100,
   parameter int          STACK_STEP = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               mode_i,
   input  stk_op_e            op_i,
   input  logic               wr_i,
   input  logic [DATA_W-1:0]  wdata_i,
   output logic [DATA_W-1:0]  sp_o,
   output logic [DATA_W-1:0]  sp_nxt_o,
   output logic [DATA_W-1:0]  stk_addr_o
);
   localparam logic [DATA_W-1:0] STEP_W = DATA_W'(STACK_STEP);
   localparam logic [DATA_W-1:0] RST_W  = DATA_W'(SP_RESET);

   logic [DATA_W-1:0] usp_q, ssp_q;

   assign sp_o = mode_i ? ssp_q : usp_q;

   always_comb begin
      if (wr_i) sp_nxt_o = wdata_i;
      else begin
         unique case (op_i)
            STK_PUSH: sp_nxt_o = sp_o - STEP_W;
            STK_POP:  sp_nxt_o = sp_o + STEP_W;
            default:  sp_nxt_o = sp_o;
         endcase
      end
   end

   assign stk_addr_o = (op_i == STK_PUSH) ? sp_o - STEP_W : sp_o;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         usp_q <= RST_W;
         ssp_q <= RST_W;
      end else if (mode_i) begin
         ssp_q <= sp_nxt_o;
      end else begin
         usp_q <= sp_nxt_o;
      end
   end
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
   import rf_pkg::*;
#(
   parameter int          DATA_W      = 16,
   parameter int          NUM_BANKS   = 4,
   parameter int          BANKED_REGS = 4,
   parameter int          NUM_REGS    = 16,
   parameter int          BYTE_REGS   = 8,
   parameter int          SP_IDX      = 7,
   parameter logic [15:0] SP_RESET    = 16'h0100,
   parameter int          STACK_STEP  = 2,
   localparam int         IDX_W       = $clog2(NUM_REGS),
   localparam int         BANK_W      = $clog2(NUM_BANKS),
   localparam int         BIDX_W      = $clog2(BANKED_REGS),
   localparam int         HALF_W      = DATA_W / 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [BANK_W-1:0]  bank_sel,
   input  logic               sys_mode,
   input  logic               wr_en,
   input  logic [IDX_W-1:0]   wr_idx,
   input  logic               wr_byte,
   input  logic               wr_hi,
   input  logic [DATA_W-1:0]  wr_data,
   output logic               wr_err,
   input  logic [IDX_W-1:0]   rd_a_idx,
   output logic [DATA_W-1:0]  rd_a_data,
   input  logic [IDX_W-1:0]   rd_b_idx,
   output logic [DATA_W-1:0]  rd_b_data,
   input  logic               push,
   input  logic               pop,
   output logic [DATA_W-1:0]  stk_addr,
   output logic [DATA_W-1:0]  sp_out
);
   if (DATA_W % 2 != 0)                 $error("DATA_W must be even");
   if (NUM_BANKS < 2)                   $error("NUM_BANKS must be at least 2");
   if (BANKED_REGS < 2)                 $error("BANKED_REGS must be at least 2");
   if (NUM_REGS != (1 << IDX_W))        $error("NUM_REGS must be a power of two");
   if (SP_IDX < BANKED_REGS || SP_IDX >= BYTE_REGS) $error("SP_IDX must be a shared byte-capable slot");
   if (BYTE_REGS > NUM_REGS)            $error("BYTE_REGS exceeds NUM_REGS");

   // status bits take effect one cycle late
   logic [BANK_W-1:0] bank_q;
   logic              mode_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bank_q <= '0;
         mode_q <= 1'b0;
      end else begin
         bank_q <= bank_sel;
         mode_q <= sys_mode;
      end
   end

   logic [BANKED_REGS-1:0][DATA_W-1:0] bank_rd;
   logic [NUM_REGS-1:0][DATA_W-1:0]    shared_rd;
   logic [NUM_REGS-1:0][DATA_W-1:0]    vis, nxt;
   logic [DATA_W-1:0]                  sp_cur, sp_nxt, wr_old, wr_merged;
   logic                               wr_ok, bank_we, shared_we, sp_we;
   stk_op_e                            stk_op;

   assign wr_err    = wr_en && wr_byte && (wr_idx >= IDX_W'(BYTE_REGS));
   assign wr_ok     = wr_en && !wr_err;
   assign bank_we   = wr_ok && (wr_idx < IDX_W'(BANKED_REGS));
   assign sp_we     = wr_ok && (wr_idx == IDX_W'(SP_IDX));
   assign shared_we = wr_ok && !bank_we && !sp_we;
   assign stk_op    = decode_stk(push, pop);

   assign wr_old = vis[wr_idx];
   always_comb begin
      if (!wr_byte)  wr_merged = wr_data;
      else if (wr_hi) wr_merged = {wr_data[HALF_W-1:0], wr_old[HALF_W-1:0]};
      else            wr_merged = {wr_old[DATA_W-1:HALF_W], wr_data[HALF_W-1:0]};
   end

   rf_bank_store #(
      .DATA_W(DATA_W), .NUM_BANKS(NUM_BANKS), .BANKED_REGS(BANKED_REGS)
   ) u_banks (
      .clk(clk), .rst_n(rst_n), .bank_i(bank_q), .we_i(bank_we),
      .widx_i(wr_idx[BIDX_W-1:0]), .wdata_i(wr_merged), .rd_o(bank_rd)
   );

   rf_shared_store #(
      .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .BANKED_REGS(BANKED_REGS), .SP_IDX(SP_IDX)
   ) u_shared (
      .clk(clk), .rst_n(rst_n), .we_i(shared_we), .widx_i(wr_idx),
      .wdata_i(wr_merged), .rd_o(shared_rd)
   );

   rf_stack_ptr #(
      .DATA_W(DATA_W), .SP_RESET(SP_RESET), .STACK_STEP(STACK_STEP)
   ) u_sp (
      .clk(clk), .rst_n(rst_n), .mode_i(mode_q), .op_i(stk_op), .wr_i(sp_we),
      .wdata_i(wr_merged), .sp_o(sp_cur), .sp_nxt_o(sp_nxt), .stk_addr_o(stk_addr)
   );

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_view
      if (i < BANKED_REGS) begin : g_bank
         assign vis[i] = bank_rd[i];
      end else if (i == SP_IDX) begin : g_sp
         assign vis[i] = sp_cur;
      end else begin : g_shr
         assign vis[i] = shared_rd[i];
      end
      if (i == SP_IDX) begin : g_nsp
         assign nxt[i] = sp_nxt;
      end else begin : g_nreg
         assign nxt[i] = (wr_ok && wr_idx == IDX_W'(i)) ? wr_merged : vis[i];
      end
   end

   assign rd_a_data = nxt[rd_a_idx];
   assign rd_b_data = nxt[rd_b_idx];
   assign sp_out    = sp_cur;
endmodule

// File: rtl/rf_checker.sv
module rf_checker #(
   parameter int          DATA_W     = 16,
   parameter int          NUM_REGS   = 16,
   parameter int          SP_IDX     = 7,
   parameter logic [15:0] SP_RESET   = 16'h0100,
   parameter int          STACK_STEP = 2,
   localparam int         IDX_W      = $clog2(NUM_REGS)
) (
   input logic                            clk,
   input logic                            rst_n,
   input logic                            push,
   input logic                            pop,
   input logic                            wr_en,
   input logic [IDX_W-1:0]                wr_idx,
   input logic                            wr_err,
   input logic                            sys_mode,
   input logic                            mode_q,
   input logic [DATA_W-1:0]               sp_out,
   input logic [DATA_W-1:0]               stk_addr,
   input logic [NUM_REGS-1:0][DATA_W-1:0] shared_rd
);
   localparam logic [DATA_W-1:0] STEP_W = DATA_W'(STACK_STEP);
   logic r7_wr;
   assign r7_wr = wr_en && !wr_err && wr_idx == IDX_W'(SP_IDX);

   p_reset_sp_r7: assert property (@(posedge clk) !rst_n |=> sp_out == DATA_W'(SP_RESET));

   p_push_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !pop) |-> stk_addr == sp_out - STEP_W);

   p_push_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !pop && !r7_wr && sys_mode == mode_q) |=> sp_out == $past(sp_out) - STEP_W);

   p_pop_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !push && !r7_wr && sys_mode == mode_q) |=> sp_out == $past(sp_out) + STEP_W);

   p_pop_addr_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !push) |-> stk_addr == sp_out);

   p_err_no_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_err |=> $stable(shared_rd));

   p_both_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (push && pop && !r7_wr && sys_mode == mode_q) |=> $stable(sp_out));
endmodule

bind banked_regfile rf_checker #(
   .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .SP_IDX(SP_IDX),
   .SP_RESET(SP_RESET), .STACK_STEP(STACK_STEP)
) u_chk (
   .clk(clk), .rst_n(rst_n), .push(push), .pop(pop), .wr_en(wr_en),
   .wr_idx(wr_idx), .wr_err(wr_err), .sys_mode(sys_mode), .mode_q(mode_q),
   .sp_out(sp_out), .stk_addr(stk_addr), .shared_rd(shared_rd)
);

// File: tb/banked_regfile_tb.sv
`timescale 1ns/1ps
module banked_regfile_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  bank_sel = '0;
   logic        sys_mode = 1'b0;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_idx = '0;
   logic        wr_byte = 1'b0;
   logic        wr_hi = 1'b0;
   logic [15:0] wr_data = '0;
   logic        wr_err;
   logic [3:0]  rd_a_idx = '0;
   logic [15:0] rd_a_data;
   logic [3:0]  rd_b_idx = '0;
   logic [15:0] rd_b_data;
   logic        push = 1'b0;
   logic        pop = 1'b0;
   logic [15:0] stk_addr;
   logic [15:0] sp_out;

   int n_chk = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   banked_regfile u_dut (
      .clk(clk), .rst_n(rst_n), .bank_sel(bank_sel), .sys_mode(sys_mode),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_byte(wr_byte), .wr_hi(wr_hi),
      .wr_data(wr_data), .wr_err(wr_err), .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
      .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data), .push(push), .pop(pop),
      .stk_addr(stk_addr), .sp_out(sp_out)
   );

   typedef struct packed {
      logic [1:0]  bank;
      logic        mode;
      logic        we;
      logic [3:0]  idx;
      logic        byt;
      logic        hi;
      logic [15:0] data;
      logic [3:0]  ridx;
      logic [15:0] exp;
      logic        err;
   } vec_t;

   localparam int NV = 15;
   localparam vec_t TBL [NV] = '{
      '{2'd0,1'b0,1'b1,4'd0,1'b0,1'b0,16'h1111,4'd0,16'h1111,1'b0}, // R9 bypass
      '{2'd1,1'b0,1'b1,4'd0,1'b0,1'b0,16'h2222,4'd0,16'h2222,1'b0}, // R10 still bank 0
      '{2'd1,1'b0,1'b0,4'd0,1'b0,1'b0,16'h0000,4'd0,16'h0000,1'b0}, // R1 bank 1 empty
      '{2'd1,1'b0,1'b1,4'd0,1'b0,1'b0,16'h3333,4'd0,16'h3333,1'b0}, // R1
      '{2'd0,1'b0,1'b1,4'd4,1'b0,1'b0,16'h4444,4'd0,16'h3333,1'b0}, // R10 still bank 1
      '{2'd0,1'b0,1'b0,4'd0,1'b0,1'b0,16'h0000,4'd0,16'h2222,1'b0}, // R1 bank 0 kept
      '{2'd0,1'b0,1'b0,4'd0,1'b0,1'b0,16'h0000,4'd4,16'h4444,1'b0}, // R2
      '{2'd0,1'b0,1'b1,4'd5,1'b1,1'b1,16'h00AB,4'd5,16'hAB00,1'b0}, // R3 high byte
      '{2'd0,1'b0,1'b1,4'd5,1'b1,1'b0,16'h12CD,4'd5,16'hABCD,1'b0}, // R3 low byte
      '{2'd0,1'b0,1'b1,4'd7,1'b0,1'b0,16'h0200,4'd7,16'h0200,1'b0}, // R5 user SP
      '{2'd0,1'b1,1'b0,4'd0,1'b0,1'b0,16'h0000,4'd7,16'h0200,1'b0}, // R10 mode late
      '{2'd0,1'b1,1'b0,4'd0,1'b0,1'b0,16'h0000,4'd7,16'h0100,1'b0}, // R5 system SP
      '{2'd0,1'b0,1'b1,4'd9,1'b0,1'b0,16'hBEEF,4'd9,16'hBEEF,1'b0}, // R2 word reg
      '{2'd0,1'b0,1'b1,4'd9,1'b1,1'b0,16'h0011,4'd9,16'hBEEF,1'b1}, // R4 refused
      '{2'd0,1'b0,1'b0,4'd0,1'b0,1'b0,16'h0000,4'd7,16'h0200,1'b0}  // R5 user again
   };

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic idle();
      wr_en = 1'b0; wr_idx = '0; wr_byte = 1'b0; wr_hi = 1'b0; wr_data = '0;
      push = 1'b0; pop = 1'b0;
   endtask

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      #(5.0 * 200000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R7 reset state
      rd_a_idx = 4'd0; rd_b_idx = 4'd7;
      #1;
      chk("R7 reset R0", rd_a_data, 16'h0000);
      chk("R7 reset R7", rd_b_data, 16'h0100);
      chk("R7 reset sp_out", sp_out, 16'h0100);
      chk("R7 reset wr_err", {15'd0, wr_err}, 16'h0000);

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         idle();
         bank_sel = TBL[i].bank; sys_mode = TBL[i].mode;
         wr_en = TBL[i].we; wr_idx = TBL[i].idx; wr_byte = TBL[i].byt;
         wr_hi = TBL[i].hi; wr_data = TBL[i].data; rd_a_idx = TBL[i].ridx;
         #1;
         chk($sformatf("table row %0d read", i), rd_a_data, TBL[i].exp);
         chk($sformatf("table row %0d err (R4)", i), {15'd0, wr_err}, {15'd0, TBL[i].err});
      end

      // R6 push on user SP 0x0200
      @(negedge clk); idle(); push = 1'b1; rd_a_idx = 4'd7;
      #1;
      chk("R6 push addr", stk_addr, 16'h01FE);
      chk("R9 R7 read during push", rd_a_data, 16'h01FE);
      @(negedge clk); idle(); #1;
      chk("R6 sp after push", sp_out, 16'h01FE);
      // R8 pop
      pop = 1'b1; #1;
      chk("R8 pop addr", stk_addr, 16'h01FE);
      @(negedge clk); idle(); #1;
      chk("R8 sp after pop", sp_out, 16'h0200);
      // R11 push and pop together
      push = 1'b1; pop = 1'b1;
      @(negedge clk); idle(); #1;
      chk("R11 push+pop hold", sp_out, 16'h0200);
      // R11 write to R7 beats push
      push = 1'b1; wr_en = 1'b1; wr_idx = 4'd7; wr_data = 16'h0300;
      @(negedge clk); idle(); #1;
      chk("R11 write beats push", sp_out, 16'h0300);
      // R5/R7 system pointer push from reset value
      sys_mode = 1'b1;
      @(negedge clk); idle(); push = 1'b1; #1;
      chk("R7 first push addr", stk_addr, 16'h00FE);
      @(negedge clk); idle(); #1;
      chk("R5 system sp after push", sp_out, 16'h00FE);
      sys_mode = 1'b0;
      @(negedge clk); idle(); #1;
      chk("R5 user sp untouched", sp_out, 16'h0300);
      // R1/R2 bank 2
      bank_sel = 2'd2;
      @(negedge clk); idle(); rd_a_idx = 4'd0; rd_b_idx = 4'd4; #1;
      chk("R1 bank 2 R0", rd_a_data, 16'h0000);
      chk("R2 bank 2 R4", rd_b_data, 16'h4444);
      rd_b_idx = 4'd5; #1;
      chk("R2 bank 2 R5", rd_b_data, 16'hABCD);
      bank_sel = 2'd1;
      @(negedge clk); idle(); rd_a_idx = 4'd0; #1;
      chk("R1 bank 1 R0", rd_a_data, 16'h3333);
      // R4 byte write to R15 refused
      wr_en = 1'b1; wr_idx = 4'd15; wr_byte = 1'b1; wr_data = 16'h0055; rd_b_idx = 4'd15;
      #1;
      chk("R4 err R15", {15'd0, wr_err}, 16'h0001);
      @(negedge clk); idle(); #1;
      chk("R4 R15 unchanged", rd_b_data, 16'h0000);

      finish_run();
   end
endmodule